// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns the operand bytes that follow an opcode into a 16-bit effective address. The caller pulses a start input with the addressing mode (page-zero direct, absolute extended, or register-indexed). It then presents the operand bytes one per cycle on a valid-qualified byte port, and also supplies the current contents of the four base registers X, Y, SP and PC.

In indexed mode the first byte is a postbyte. Its bit fields choose the base register and the offset width: a 5-bit offset held inside the postbyte, a 9-bit offset whose top bit sits in the postbyte, or a 16-bit offset in two following bytes. The unit finds the sequence length from the postbyte, collects the remaining bytes, adds the sign-extended offset to the selected base and raises a one-cycle done pulse together with the address and the number of bytes consumed. The base-register inputs are only read.

Postbytes outside the supported forms, and the reserved mode code, end the sequence at once with an illegal flag. Done is combinational on the cycle the final byte is accepted, so the consumer can use the address in that same cycle.

Top module: `ea_gen`

## Requirements
- R1: Mode code 2'b00 (direct) consumes one byte B and returns address {8'h00, B} with a byte count of 1.
- R2: Mode code 2'b01 (extended) consumes two bytes, high then low, returns them concatenated unchanged, and reports a count of 2. Done stays low on the first byte.
- R3: In mode code 2'b10 (indexed), a postbyte with bit 5 clear uses bits 4:0 as a two's-complement offset, selects the base with bits 7:6, and completes after that single byte.
- R4: An indexed postbyte matching 111ss00h uses h as the sign/top bit of a 9-bit offset whose low 8 bits come from the next byte, selects the base with bits 4:3 (ss), and reports a count of 2.
- R5: An indexed postbyte equal to 111ss010 takes a 16-bit offset from the next two bytes, high byte first, selects the base with bits 4:3, and reports a count of 3.
- R6: The base-select code maps 00 to X, 01 to Y, 10 to SP and 11 to PC.
- R7: Base plus offset wraps modulo 2^ADDR_W, and no carry indication is given.
- R8: An indexed postbyte with bit 5 set that matches neither R4 nor R5 completes on that byte with illegal high, address 0 and count 1. Mode code 2'b11 is reserved and behaves the same on its first byte.
- R9: Done is high for exactly the cycle in which the final operand byte is accepted. Whenever done is low, the address, count and illegal outputs are zero.
- R10: Start discards any partly collected sequence and latches the new mode. A byte presented in the same cycle as start is taken as the first byte of the new sequence.
- R11: After completion or reset, bytes presented without a start are ignored: no done is produced, and the next started sequence is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new operand sequence |
| mode_i | input | 2 | Addressing mode, sampled with start_i |
| byte_valid_i | input | 1 | Operand byte present this cycle |
| byte_i | input | 8 | Operand byte |
| reg_x_i | input | ADDR_W | Current X register |
| reg_y_i | input | ADDR_W | Current Y register |
| reg_sp_i | input | ADDR_W | Current stack pointer |
| reg_pc_i | input | ADDR_W | Current program counter |
| ea_o | output | ADDR_W | Effective address, valid with done_o |
| done_o | output | 1 | Final operand byte accepted this cycle |
| nbytes_o | output | 2 | Operand bytes consumed (1 to 3) |
| illegal_o | output | 1 | Unsupported postbyte or reserved mode |

## Verification
The bench builds the block with ADDR_W at its default of 16. At that width the carry out of bit 15 is discarded, so PC-relative offsets that cross 0xFFFF show the wrap directly. Direct addresses likewise show a page-zero high byte across the full 16-bit result. The register values are fixed near 0x2000, 0x3000, 0x0FF0 and 0xFFF0. With those values, negative 5-, 9- and 16-bit offsets give results that are easy to predict. A PC base close to the top of the space lets small positive offsets reach the wrap.

// File: rtl/eag_pkg.sv
package eag_pkg;
   localparam int BYTE_W    = 8;
   localparam int NUM_BASE  = 4;
   localparam int MAX_BYTES = 3;
   localparam int CNT_W     = 2;

   typedef enum logic [1:0] {
      AM_DIR = 2'b00,
      AM_EXT = 2'b01,
      AM_IDX = 2'b10,
      AM_RSV = 2'b11
   } am_e;

   typedef enum logic [1:0] {
      IX_OFF5  = 2'b00,
      IX_OFF9  = 2'b01,
      IX_OFF16 = 2'b10,
      IX_BAD   = 2'b11
   } ixform_e;
endpackage

// File: rtl/eag_collector.sv
module eag_collector
   import eag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  am_e               mode_i,
   input  logic              byte_valid_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              last_i,
   output logic              accept_o,
   output logic              active_o,
   output am_e               cur_mode_o,
   output logic [CNT_W-1:0]  cur_idx_o,
   output logic [BYTE_W-1:0] view_o [MAX_BYTES]
);
   localparam int HOLD = MAX_BYTES - 1;

   logic              active_q;
   am_e               mode_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] hold_q [HOLD];

   assign cur_mode_o = start_i ? mode_i : mode_q;
   assign cur_idx_o  = start_i ? '0 : cnt_q;
   assign accept_o   = byte_valid_i && (start_i || active_q);
   assign active_o   = active_q;

   // Bytes already held come from storage; the byte at the current slot comes live.
   for (genvar k = 0; k < HOLD; k++) begin : g_view
      assign view_o[k] = (cur_idx_o == CNT_W'(k)) ? byte_i : hold_q[k];
   end
   assign view_o[HOLD] = byte_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         mode_q   <= AM_DIR;
         cnt_q    <= '0;
      end else begin
         if (start_i) begin
            active_q <= 1'b1;
            mode_q   <= mode_i;
            cnt_q    <= '0;
         end
         if (accept_o) begin
            if (last_i) begin
               active_q <= 1'b0;
               cnt_q    <= '0;
            end else begin
               cnt_q <= cur_idx_o + CNT_W'(1);
            end
         end
      end
   end

   for (genvar k = 0; k < HOLD; k++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold_q[k] <= '0;
         else if (accept_o && !last_i && cur_idx_o == CNT_W'(k))
            hold_q[k] <= byte_i;
      end
   end

   // R5: never more than two bytes are held waiting
   p_hold_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(HOLD));

   // R10: a start without a byte leaves an empty, active collector
   p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !byte_valid_i) |=> (active_q && cnt_q == '0));
endmodule

// File: rtl/eag_postbyte_dec.sv
module eag_postbyte_dec
   import eag_pkg::*;
(
   input  logic [BYTE_W-1:0] pb_i,
   output ixform_e           form_o,
   output logic [1:0]        sel_o,
   output logic [CNT_W-1:0]  need_o
);
   always_comb begin
      form_o = IX_BAD;
      sel_o  = 2'b00;
      need_o = CNT_W'(1);
      if (!pb_i[5]) begin
         form_o = IX_OFF5;
         sel_o  = pb_i[7:6];
         need_o = CNT_W'(1);
      end else if (pb_i[7:5] == 3'b111 && pb_i[2:1] == 2'b00) begin
         form_o = IX_OFF9;
         sel_o  = pb_i[4:3];
         need_o = CNT_W'(2);
      end else if (pb_i[7:5] == 3'b111 && pb_i[2:0] == 3'b010) begin
         form_o = IX_OFF16;
         sel_o  = pb_i[4:3];
         need_o = CNT_W'(3);
      end
   end
endmodule

// File: rtl/eag_base_sel.sv
module eag_base_sel
   import eag_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] base_i [NUM_BASE],
   input  logic [1:0]        sel_i,
   output logic [ADDR_W-1:0] base_o
);
   logic [ADDR_W-1:0] masked [NUM_BASE];

   for (genvar g = 0; g < NUM_BASE; g++) begin : g_mask
      assign masked[g] = (sel_i == 2'(g)) ? base_i[g] : '0;
   end

   always_comb begin
      base_o = '0;
      for (int k = 0; k < NUM_BASE; k++) base_o |= masked[k];
   end
endmodule

// File: rtl/eag_addr_form.sv
module eag_addr_form
   import eag_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  am_e               mode_i,
   input  ixform_e           form_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [BYTE_W-1:0] b0_i,
   input  logic [BYTE_W-1:0] b1_i,
   input  logic [BYTE_W-1:0] b2_i,
   output logic [ADDR_W-1:0] ea_o
);
   localparam int PAD5  = ADDR_W - 5;
   localparam int PAD9  = ADDR_W - 9;
   localparam int PAD16 = ADDR_W - 16;

   logic [ADDR_W-1:0] off5, off9, off16, offset;

   assign off5 = {{PAD5{b0_i[4]}}, b0_i[4:0]};
   assign off9 = {{PAD9{b0_i[0]}}, b0_i[0], b1_i};

   if (PAD16 > 0) begin : g_wide
      assign off16 = {{PAD16{b1_i[7]}}, b1_i, b2_i};
   end else begin : g_exact
      assign off16 = {b1_i, b2_i};
   end

   always_comb begin
      case (form_i)
         IX_OFF5:  offset = off5;
         IX_OFF9:  offset = off9;
         IX_OFF16: offset = off16;
         default:  offset = '0;
      endcase
   end

   always_comb begin
      case (mode_i)
         AM_DIR:  ea_o = ADDR_W'(b0_i);
         AM_EXT:  ea_o = ADDR_W'({b0_i, b1_i});
         AM_IDX:  ea_o = (form_i == IX_BAD) ? '0 : base_i + offset;
         default: ea_o = '0;
      endcase
   end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import eag_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic              byte_valid_i,
   input  logic [7:0]        byte_i,
   input  logic [ADDR_W-1:0] reg_x_i,
   input  logic [ADDR_W-1:0] reg_y_i,
   input  logic [ADDR_W-1:0] reg_sp_i,
   input  logic [ADDR_W-1:0] reg_pc_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic              done_o,
   output logic [1:0]        nbytes_o,
   output logic              illegal_o
);
   if (ADDR_W < 16) begin : g_bad_width
      $error("ea_gen: ADDR_W must be at least 16");
   end

   logic              accept, active, last;
   am_e               cur_mode;
   logic [CNT_W-1:0]  cur_idx;
   logic [BYTE_W-1:0] view [MAX_BYTES];
   ixform_e           form;
   logic [1:0]        sel;
   logic [CNT_W-1:0]  idx_need, need;
   logic              bad;
   logic [ADDR_W-1:0] bases [NUM_BASE];
   logic [ADDR_W-1:0] base, ea_raw;

   eag_collector u_collector (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .mode_i       (am_e'(mode_i)),
      .byte_valid_i (byte_valid_i),
      .byte_i       (byte_i),
      .last_i       (last),
      .accept_o     (accept),
      .active_o     (active),
      .cur_mode_o   (cur_mode),
      .cur_idx_o    (cur_idx),
      .view_o       (view)
   );

   eag_postbyte_dec u_dec (
      .pb_i   (view[0]),
      .form_o (form),
      .sel_o  (sel),
      .need_o (idx_need)
   );

   assign bases[0] = reg_x_i;
   assign bases[1] = reg_y_i;
   assign bases[2] = reg_sp_i;
   assign bases[3] = reg_pc_i;

   eag_base_sel #(.ADDR_W(ADDR_W)) u_base (
      .base_i (bases),
      .sel_i  (sel),
      .base_o (base)
   );

   eag_addr_form #(.ADDR_W(ADDR_W)) u_form (
      .mode_i (cur_mode),
      .form_i (form),
      .base_i (base),
      .b0_i   (view[0]),
      .b1_i   (view[1]),
      .b2_i   (view[2]),
      .ea_o   (ea_raw)
   );

   always_comb begin
      case (cur_mode)
         AM_DIR:  need = CNT_W'(1);
         AM_EXT:  need = CNT_W'(2);
         AM_IDX:  need = idx_need;
         default: need = CNT_W'(1);
      endcase
   end

   assign bad       = (cur_mode == AM_RSV) || (cur_mode == AM_IDX && form == IX_BAD);
   assign last      = accept && (CNT_W'(cur_idx + CNT_W'(1)) == need);
   assign done_o    = last;
   assign illegal_o = last && bad;
   assign nbytes_o  = last ? need : 2'd0;
   assign ea_o      = (last && !bad) ? ea_raw : '0;

   // R9: done cannot repeat unless a new sequence starts
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (start_i || !done_o));

   // R9: result outputs are quiet outside the done cycle
   p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (ea_o == '0 && nbytes_o == 2'd0 && !illegal_o));

   // R8: an illegal completion carries a zero address after one byte
   p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (ea_o == '0 && nbytes_o == 2'd1));

   // R1: direct results stay in page zero
   p_dir_page0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cur_mode == AM_DIR) |-> (ea_o[ADDR_W-1:8] == '0 && nbytes_o == 2'd1));

   // R2: extended always takes two bytes
   p_ext_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cur_mode == AM_EXT) |-> nbytes_o == 2'd2);

   // R11: no completion without an open sequence
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start_i) |-> !done_o);
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 16;
   localparam int NVEC   = 18;

   // fields: mode[47:46] n[45:44] b0[43:36] b1[35:28] b2[27:20] ea[19:4] cnt[3:2] ill[1] pad[0]
   localparam logic [47:0] VEC [NVEC] = '{
      {2'd0, 2'd1, 8'h80, 8'h00, 8'h00, 16'h0080, 2'd1, 1'b0, 1'b0}, // R1
      {2'd1, 2'd2, 8'h30, 8'h00, 8'h00, 16'h3000, 2'd2, 1'b0, 1'b0}, // R2
      {2'd2, 2'd1, 8'h44, 8'h00, 8'h00, 16'h2004, 2'd1, 1'b0, 1'b0}, // R3 Y+4
      {2'd2, 2'd1, 8'h10, 8'h00, 8'h00, 16'h2FF1, 2'd1, 1'b0, 1'b0}, // R3 X-16
      {2'd2, 2'd1, 8'h8F, 8'h00, 8'h00, 16'h0FFF, 2'd1, 1'b0, 1'b0}, // R6 SP+15
      {2'd2, 2'd2, 8'hE1, 8'h9C, 8'h00, 16'h2F9D, 2'd2, 1'b0, 1'b0}, // R4 X-100
      {2'd2, 2'd2, 8'hE8, 8'hFF, 8'h00, 16'h20FF, 2'd2, 1'b0, 1'b0}, // R4 Y+255
      {2'd2, 2'd3, 8'hEA, 8'hFC, 8'h18, 16'h1C18, 2'd3, 1'b0, 1'b0}, // R5 Y-1000
      {2'd2, 2'd3, 8'hFA, 8'h00, 8'h20, 16'h0010, 2'd3, 1'b0, 1'b0}, // R7 PC+32
      {2'd2, 2'd2, 8'hF8, 8'hFF, 8'h00, 16'h00EF, 2'd2, 1'b0, 1'b0}, // R7 PC+255
      {2'd2, 2'd1, 8'hE3, 8'h00, 8'h00, 16'h0000, 2'd1, 1'b1, 1'b0}, // R8
      {2'd2, 2'd1, 8'hE4, 8'h00, 8'h00, 16'h0000, 2'd1, 1'b1, 1'b0}, // R8
      {2'd2, 2'd1, 8'hA0, 8'h00, 8'h00, 16'h0000, 2'd1, 1'b1, 1'b0}, // R8
      {2'd3, 2'd1, 8'h00, 8'h00, 8'h00, 16'h0000, 2'd1, 1'b1, 1'b0}, // R8 reserved mode
      {2'd2, 2'd1, 8'hDF, 8'h00, 8'h00, 16'hFFEF, 2'd1, 1'b0, 1'b0}, // R6 PC-1
      {2'd2, 2'd3, 8'hE2, 8'h7F, 8'hFF, 16'hB000, 2'd3, 1'b0, 1'b0}, // R5 X+7FFF
      {2'd1, 2'd2, 8'hFF, 8'hFF, 8'h00, 16'hFFFF, 2'd2, 1'b0, 1'b0}, // R2
      {2'd2, 2'd1, 8'hC0, 8'h00, 8'h00, 16'hFFF0, 2'd1, 1'b0, 1'b0}  // R6 PC+0
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [1:0]        mode_i = 2'd0;
   logic              byte_valid_i = 1'b0;
   logic [7:0]        byte_i = 8'h00;
   logic [ADDR_W-1:0] reg_x_i  = 16'h3001;
   logic [ADDR_W-1:0] reg_y_i  = 16'h2000;
   logic [ADDR_W-1:0] reg_sp_i = 16'h0FF0;
   logic [ADDR_W-1:0] reg_pc_i = 16'hFFF0;
   logic [ADDR_W-1:0] ea_o;
   logic              done_o;
   logic [1:0]        nbytes_o;
   logic              illegal_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   ea_gen #(.ADDR_W(ADDR_W)) u_ea_gen (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .mode_i (mode_i),
      .byte_valid_i (byte_valid_i), .byte_i (byte_i),
      .reg_x_i (reg_x_i), .reg_y_i (reg_y_i), .reg_sp_i (reg_sp_i), .reg_pc_i (reg_pc_i),
      .ea_o (ea_o), .done_o (done_o), .nbytes_o (nbytes_o), .illegal_o (illegal_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic s, input logic [1:0] m, input logic v, input logic [7:0] b);
      @(negedge clk);
      start_i = s; mode_i = m; byte_valid_i = v; byte_i = b;
      #1;
   endtask

   task automatic chk_result(input string req, input logic [15:0] ea,
                             input logic [1:0] n, input logic ill);
      chk({req, " done"}, 32'(done_o), 32'd1);
      chk({req, " ea"}, 32'(ea_o), 32'(ea));
      chk({req, " count"}, 32'(nbytes_o), 32'(n));
      chk({req, " illegal"}, 32'(illegal_o), 32'(ill));
   endtask

   function automatic string tag_of(input int i);
      case (i)
         0:                return "R1";
         1, 16:            return "R2";
         2, 3:             return "R3";
         5, 6:             return "R4";
         7, 15:            return "R5";
         8, 9:             return "R7";
         10, 11, 12, 13:   return "R8";
         default:          return "R6";
      endcase
   endfunction

   initial begin
      #(CLK_P * 50000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 reset done", 32'(done_o), 32'd0);
      chk("R9 reset ea", 32'(ea_o), 32'd0);
      chk("R9 reset count", 32'(nbytes_o), 32'd0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [47:0] v;
         int n;
         v = VEC[i];
         n = int'(v[45:44]);
         for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = (k == 0) ? v[43:36] : (k == 1) ? v[35:28] : v[27:20];
            put(k == 0, v[47:46], 1'b1, b);
            if (k == n - 1) begin
               chk_result(tag_of(i), v[19:4], v[3:2], v[1]);
            end else begin
               chk({tag_of(i), " early done"}, 32'(done_o), 32'd0);
               if (i % 2 == 1) begin
                  put(1'b0, 2'd0, 1'b0, 8'h00);
                  chk({tag_of(i), " gap"}, 32'(done_o), 32'd0);
               end
            end
         end
         put(1'b0, 2'd0, 1'b0, 8'h00);
         chk("R9 pulse ends", 32'(done_o), 32'd0);
      end

      // R11: stray bytes after completion are ignored
      for (int k = 0; k < 3; k++) begin
         put(1'b0, 2'd2, 1'b1, 8'h44);
         chk("R11 stray byte", 32'(done_o), 32'd0);
      end
      put(1'b1, 2'd0, 1'b1, 8'h12);
      chk_result("R11 after stray", 16'h0012, 2'd1, 1'b0);

      // R10: restart discards a half-collected extended sequence
      put(1'b1, 2'd1, 1'b1, 8'h55);
      chk("R10 partial", 32'(done_o), 32'd0);
      put(1'b1, 2'd0, 1'b1, 8'h21);
      chk_result("R10 restart", 16'h0021, 2'd1, 1'b0);

      // R10: restart a 16-bit indexed sequence after two bytes
      put(1'b1, 2'd2, 1'b1, 8'hEA);
      put(1'b0, 2'd2, 1'b1, 8'h00);
      chk("R10 partial idx", 32'(done_o), 32'd0);
      put(1'b1, 2'd1, 1'b1, 8'hAB);
      put(1'b0, 2'd0, 1'b1, 8'hCD);
      chk_result("R10 restart ext", 16'hABCD, 2'd2, 1'b0);

      // R10: start alone, byte next cycle
      put(1'b1, 2'd0, 1'b0, 8'h99);
      chk("R10 start only", 32'(done_o), 32'd0);
      put(1'b0, 2'd3, 1'b1, 8'h7E);
      chk_result("R10 late byte", 16'h007E, 2'd1, 1'b0);

      // R11: reset in mid-sequence, then bytes without start
      put(1'b1, 2'd1, 1'b1, 8'h11);
      @(negedge clk); rst_n = 1'b0; start_i = 1'b0; byte_valid_i = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      put(1'b0, 2'd1, 1'b1, 8'h22);
      chk("R11 after reset", 32'(done_o), 32'd0);
      put(1'b1, 2'd2, 1'b1, 8'h04);
      chk_result("R3 after reset", 16'h3005, 2'd1, 1'b0);
      put(1'b0, 2'd0, 1'b0, 8'h00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule